// File: doc/BRIEF.md
# Multi-Mode Timer with PWM

This block is a 16-bit timer built from two 8-bit halves, a low half and a high half. The same two halves serve four operating modes. In the first, they are two separate 8-bit interval timers. In the second, the low half is an interval timer and the high half is an 8-bit PWM generator. In the third, the halves are joined into one 16-bit interval timer. In the fourth, they form a PWM whose period width can be programmed anywhere from 9 to 16 bits. Counting is paced by two enable inputs: a once-per-cycle tick and a twice-per-cycle (half-cycle) tick. The half-cycle tick can only be chosen in the two 16-bit modes.

Software sets the periods, the compare values and the PWM width over a simple write-only register bus. The low half and the high half each own a sticky event flag. Both flags feed one shared interrupt request. In the PWM modes, a new compare value is held in a shadow register and only takes effect when the period wraps, so the output never glitches.

A small state machine tracks the running mode. It has five named states: `S_SWITCH`, `S_DUAL`, `S_MIXED`, `S_WIDE` and `S_VARPWM`. Reset enters `S_SWITCH`. From `S_SWITCH`, the next cycle always goes to the run state that the mode input selects: mode 0 goes to `S_DUAL`, 1 to `S_MIXED`, 2 to `S_WIDE` and 3 to `S_VARPWM`. From a run state, the machine stays where it is while the mode input still selects that state. When the mode input selects a different state, it moves to `S_SWITCH`. In `S_SWITCH` nothing counts, both halves clear, and the shadow compare loads for the target mode.

The registers, by write address (`wr_addr`):

| Address | Content |
|---|---|
| 0 | low period |
| 1 | high period |
| 2 | low compare byte |
| 3 | high compare byte |
| 4 | flag clear: bit 0 clears the low flag, bit 1 clears the high flag |
| 5 | PWM width code in bits 2:0; width = 9 + code |

All registers reset to zero.

Top module: `mm_timer_pwm`

## Requirements
- R1: After reset, `pwm_out`, `flag_lo`, `flag_hi` and `irq` are 0, and both halves count from 0.
- R2: In mode 0 (`S_DUAL`), each half advances on every cycle with `tick_full`=1. When a half's count equals its period register on such a cycle, that half reloads to 0 and sets its own flag. A count that is above its period wraps through 255 to 0.
- R3: In mode 1 (`S_MIXED`), the low half is an R2 timer. The high half is an 8-bit PWM counter that advances on `tick_full`. It wraps from 255 to 0, and on that wrap it sets `flag_hi`.
- R4: In mode 2 (`S_WIDE`), the count {high, low} advances as one 16-bit value. When it equals {high period, low period} on a tick, it reloads to 0 and sets `flag_hi`. In modes 2 and 3 `flag_lo` is never set.
- R5: In mode 3 (`S_VARPWM`), the period width is W = 9 + code (address 5). The 16-bit count wraps to 0 on a tick where it is at or above 2^W−1, and that wrap sets `flag_hi`.
- R6: In modes 0 and 1, counting uses only `tick_full`. In modes 2 and 3, counting uses `tick_half` when `fine_res`=1 and `tick_full` otherwise.
- R7: In the PWM modes, `pwm_out` is high when the PWM count is below the shadow compare, or when the shadow compare is at or above the wrap value (255 in mode 1, 2^W−1 in mode 3). A shadow compare of 0 gives a constant low. `pwm_out` is 0 in modes 0 and 2 and in `S_SWITCH`.
- R8: The shadow compare loads only on a PWM wrap or in `S_SWITCH`. In mode 1 it is {0, high compare byte}; in mode 3 it is {high compare byte, low compare byte}. Compare writes made mid-period therefore do not change `pwm_out` until the next period.
- R9: A set flag stays set until a write to address 4 with a 1 in its bit. A set and a clear of the same flag in the same cycle leaves the flag set. `irq` is the OR of the two flags.
- R10: A mode change passes through exactly one `S_SWITCH` cycle, in which nothing counts and both halves clear. Counting resumes in the new mode on the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous reset, active low |
| tick_full | input | 1 | once-per-cycle count enable |
| tick_half | input | 1 | half-cycle count enable (modes 2 and 3) |
| fine_res | input | 1 | selects `tick_half` in modes 2 and 3 |
| mode_sel | input | 2 | operating mode 0..3 |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | register address |
| wr_data | input | 8 | register write data |
| pwm_out | output | 1 | PWM output |
| flag_lo | output | 1 | low-half event flag |
| flag_hi | output | 1 | high-half event flag |
| irq | output | 1 | shared interrupt request |

## Verification
The hardest case to reach is the full 16-bit PWM period in mode 3. With width code 7, the counter must step 65,535 times before it wraps, refreshes the shadow and raises `flag_hi`. The stimulus gets there in a single directed run with `fine_res` and `tick_half` held high, and it writes a new compare mid-period so the shadow hold is seen at that large period. Random phases with a fixed seed then mix mode changes, sparse ticks, small periods and same-cycle flag set and clear. A bench model derived from the requirements predicts every output on every cycle.

// File: rtl/mm_timer_pkg.sv
package mm_timer_pkg;

    typedef enum logic [2:0] {
        S_SWITCH,
        S_DUAL,
        S_MIXED,
        S_WIDE,
        S_VARPWM
    } run_st_t;

    localparam logic [2:0] ADDR_PER_LO = 3'd0;
    localparam logic [2:0] ADDR_PER_HI = 3'd1;
    localparam logic [2:0] ADDR_CMP_LO = 3'd2;
    localparam logic [2:0] ADDR_CMP_HI = 3'd3;
    localparam logic [2:0] ADDR_FLAGS  = 3'd4;
    localparam logic [2:0] ADDR_WIDTH  = 3'd5;

    function automatic run_st_t mode_state(input logic [1:0] m);
        unique case (m)
            2'd0: mode_state = S_DUAL;
            2'd1: mode_state = S_MIXED;
            2'd2: mode_state = S_WIDE;
            2'd3: mode_state = S_VARPWM;
        endcase
    endfunction

endpackage

// File: rtl/mm_timer_fsm.sv
module mm_timer_fsm
    import mm_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    output run_st_t    st,
    output run_st_t    tgt
);
    run_st_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_SWITCH;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_SWITCH: st_d = mode_state(mode_sel);
            S_DUAL, S_MIXED, S_WIDE, S_VARPWM:
                st_d = (mode_state(mode_sel) != st_q) ? S_SWITCH : st_q;
        endcase
    end

    always_comb begin
        st  = st_q;
        tgt = mode_state(mode_sel);
    end

    // R10
    switch_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_SWITCH && st_q != mode_state(mode_sel)) |=> (st_q == S_SWITCH));

endmodule

// File: rtl/mm_timer_regs.sv
module mm_timer_regs
    import mm_timer_pkg::*;
#(
    parameter int HW = 8,
    parameter int CW = $clog2(HW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [HW-1:0] wr_data,
    input  logic          set_lo,
    input  logic          set_hi,
    output logic [HW-1:0] per_lo,
    output logic [HW-1:0] per_hi,
    output logic [HW-1:0] cmp_lo,
    output logic [HW-1:0] cmp_hi,
    output logic [CW-1:0] wcode,
    output logic          flag_lo,
    output logic          flag_hi
);
    logic flag_lo_q, flag_hi_q, clr_hit;

    assign clr_hit = wr_en && (wr_addr == ADDR_FLAGS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_lo <= '0;
            per_hi <= '0;
            cmp_lo <= '0;
            cmp_hi <= '0;
            wcode  <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_PER_LO: per_lo <= wr_data;
                ADDR_PER_HI: per_hi <= wr_data;
                ADDR_CMP_LO: cmp_lo <= wr_data;
                ADDR_CMP_HI: cmp_hi <= wr_data;
                ADDR_WIDTH:  wcode  <= wr_data[CW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_lo_q <= 1'b0;
            flag_hi_q <= 1'b0;
        end else begin
            flag_lo_q <= set_lo | (flag_lo_q & ~(clr_hit & wr_data[0]));
            flag_hi_q <= set_hi | (flag_hi_q & ~(clr_hit & wr_data[1]));
        end
    end

    assign flag_lo = flag_lo_q;
    assign flag_hi = flag_hi_q;

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_lo_q && !(clr_hit && wr_data[0])) |=> flag_lo_q);

    // R9
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_hi_q) |-> $past(set_hi));

endmodule

// File: rtl/mm_timer_core.sv
module mm_timer_core
    import mm_timer_pkg::*;
#(
    parameter int HW = 8,
    parameter int CW = $clog2(HW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  run_st_t       st,
    input  run_st_t       tgt,
    input  logic          tick_full,
    input  logic          tick_half,
    input  logic          fine_res,
    input  logic [HW-1:0] per_lo,
    input  logic [HW-1:0] per_hi,
    input  logic [HW-1:0] cmp_lo,
    input  logic [HW-1:0] cmp_hi,
    input  logic [CW-1:0] wcode,
    output logic          set_lo,
    output logic          set_hi,
    output logic          pwm_out
);
    localparam int FW = 2 * HW;
    localparam logic [CW-1:0] SH_BASE = CW'(HW - 1);

    logic [FW-1:0] cnt_q, cnt_d, shd_q, shd_d, mask_v, per_full, cmp_full, hi_wrap;
    logic [HW-1:0] lo_q, hi_q;
    logic [HW:0]   lo_s, hi_s;
    logic [CW-1:0] shamt;
    logic          tick_sel;

    // returns {hit, next count} for one 8-bit interval half
    function automatic logic [HW:0] half_step(input logic [HW-1:0] c, input logic [HW-1:0] p);
        if (c == p) half_step = {1'b1, {HW{1'b0}}};
        else        half_step = {1'b0, c + 1'b1};
    endfunction

    assign lo_q     = cnt_q[HW-1:0];
    assign hi_q     = cnt_q[FW-1:HW];
    assign per_full = {per_hi, per_lo};
    assign cmp_full = {cmp_hi, cmp_lo};
    assign hi_wrap  = {{HW{1'b0}}, {HW{1'b1}}};
    assign shamt    = SH_BASE - wcode;
    assign mask_v   = {FW{1'b1}} >> shamt;
    assign tick_sel = fine_res ? tick_half : tick_full;

    always_comb begin
        cnt_d  = cnt_q;
        shd_d  = shd_q;
        set_lo = 1'b0;
        set_hi = 1'b0;
        lo_s   = '0;
        hi_s   = '0;
        unique case (st)
            S_SWITCH: begin
                cnt_d = '0;
                shd_d = (tgt == S_VARPWM) ? cmp_full : {{HW{1'b0}}, cmp_hi};
            end
            S_DUAL: begin
                if (tick_full) begin
                    lo_s   = half_step(lo_q, per_lo);
                    hi_s   = half_step(hi_q, per_hi);
                    cnt_d  = {hi_s[HW-1:0], lo_s[HW-1:0]};
                    set_lo = lo_s[HW];
                    set_hi = hi_s[HW];
                end
            end
            S_MIXED: begin
                if (tick_full) begin
                    lo_s   = half_step(lo_q, per_lo);
                    set_lo = lo_s[HW];
                    cnt_d[HW-1:0] = lo_s[HW-1:0];
                    if (hi_q == {HW{1'b1}}) begin
                        cnt_d[FW-1:HW] = '0;
                        set_hi = 1'b1;
                        shd_d  = {{HW{1'b0}}, cmp_hi};
                    end else begin
                        cnt_d[FW-1:HW] = hi_q + 1'b1;
                    end
                end
            end
            S_WIDE: begin
                if (tick_sel) begin
                    if (cnt_q == per_full) begin
                        cnt_d  = '0;
                        set_hi = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            S_VARPWM: begin
                if (tick_sel) begin
                    if (cnt_q >= mask_v) begin
                        cnt_d  = '0;
                        set_hi = 1'b1;
                        shd_d  = cmp_full;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            shd_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            shd_q <= shd_d;
        end
    end

    always_comb begin
        pwm_out = 1'b0;
        unique case (st)
            S_MIXED:  pwm_out = ({{HW{1'b0}}, hi_q} < shd_q) || (shd_q >= hi_wrap);
            S_VARPWM: pwm_out = (cnt_q < shd_q) || (shd_q >= mask_v);
            S_SWITCH, S_DUAL, S_WIDE: pwm_out = 1'b0;
        endcase
    end

    // R10
    switch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SWITCH) |=> (cnt_q == '0));

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_SWITCH && !set_hi) |=> $stable(shd_q));

    // R4
    no_lo_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WIDE || st == S_VARPWM) |-> !set_lo);

endmodule

// File: rtl/mm_timer_pwm.sv
module mm_timer_pwm
    import mm_timer_pkg::*;
#(
    parameter int HW = 8,
    parameter int CW = $clog2(HW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_full,
    input  logic          tick_half,
    input  logic          fine_res,
    input  logic [1:0]    mode_sel,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [HW-1:0] wr_data,
    output logic          pwm_out,
    output logic          flag_lo,
    output logic          flag_hi,
    output logic          irq
);
    run_st_t       st, tgt;
    logic          set_lo, set_hi;
    logic [HW-1:0] per_lo, per_hi, cmp_lo, cmp_hi;
    logic [CW-1:0] wcode;

    mm_timer_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .st       (st),
        .tgt      (tgt)
    );

    mm_timer_regs #(.HW(HW), .CW(CW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .set_lo  (set_lo),
        .set_hi  (set_hi),
        .per_lo  (per_lo),
        .per_hi  (per_hi),
        .cmp_lo  (cmp_lo),
        .cmp_hi  (cmp_hi),
        .wcode   (wcode),
        .flag_lo (flag_lo),
        .flag_hi (flag_hi)
    );

    mm_timer_core #(.HW(HW), .CW(CW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .st        (st),
        .tgt       (tgt),
        .tick_full (tick_full),
        .tick_half (tick_half),
        .fine_res  (fine_res),
        .per_lo    (per_lo),
        .per_hi    (per_hi),
        .cmp_lo    (cmp_lo),
        .cmp_hi    (cmp_hi),
        .wcode     (wcode),
        .set_lo    (set_lo),
        .set_hi    (set_hi),
        .pwm_out   (pwm_out)
    );

    assign irq = flag_lo | flag_hi;

endmodule

// File: tb/tb_mm_timer_pwm.sv
`timescale 1ns/1ps
module tb_mm_timer_pwm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_full = 1'b0, tick_half = 1'b0, fine_res = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic       pwm_out, flag_lo, flag_hi, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_st, m_cnt, m_shd, m_flo, m_fhi, m_pl, m_ph, m_cl, m_ch, m_wc;

    always #2 clk = ~clk;

    mm_timer_pwm dut (
        .clk(clk), .rst_n(rst_n), .tick_full(tick_full), .tick_half(tick_half),
        .fine_res(fine_res), .mode_sel(mode_sel), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .flag_lo(flag_lo), .flag_hi(flag_hi),
        .irq(irq)
    );

    task automatic model_reset();
        m_st = 0; m_cnt = 0; m_shd = 0; m_flo = 0; m_fhi = 0;
        m_pl = 0; m_ph = 0; m_cl = 0; m_ch = 0; m_wc = 0;
    endtask

    function automatic int exp_pwm();
        int mask;
        mask = (1 << (9 + m_wc)) - 1;
        if (m_st == 2) return (((m_cnt >> 8) & 255) < m_shd || m_shd >= 255) ? 1 : 0;
        if (m_st == 4) return (m_cnt < m_shd || m_shd >= mask) ? 1 : 0;
        return 0;
    endfunction

    task automatic model_next(int md, bit tf, bit th, bit fr, bit we, int a, int d);
        int lo, hi, slo, shi, mask, tsel, nst, ncnt, nshd, clr;
        lo = m_cnt & 255; hi = (m_cnt >> 8) & 255;
        slo = 0; shi = 0; ncnt = m_cnt; nshd = m_shd; nst = m_st;
        tsel = fr ? int'(th) : int'(tf);
        mask = (1 << (9 + m_wc)) - 1;
        case (m_st)
            0: begin ncnt = 0; nshd = (md == 3) ? (m_ch * 256 + m_cl) : m_ch; nst = md + 1; end
            1: if (tf) begin
                if (lo == m_pl) begin lo = 0; slo = 1; end else lo = (lo + 1) & 255;
                if (hi == m_ph) begin hi = 0; shi = 1; end else hi = (hi + 1) & 255;
                ncnt = hi * 256 + lo;
            end
            2: if (tf) begin
                if (lo == m_pl) begin lo = 0; slo = 1; end else lo = (lo + 1) & 255;
                if (hi == 255) begin hi = 0; shi = 1; nshd = m_ch; end else hi = hi + 1;
                ncnt = hi * 256 + lo;
            end
            3: if (tsel != 0) begin
                if (m_cnt == m_ph * 256 + m_pl) begin ncnt = 0; shi = 1; end
                else ncnt = (m_cnt + 1) & 65535;
            end
            4: if (tsel != 0) begin
                if (m_cnt >= mask) begin ncnt = 0; shi = 1; nshd = m_ch * 256 + m_cl; end
                else ncnt = m_cnt + 1;
            end
            default: ;
        endcase
        if (m_st != 0 && md + 1 != m_st) nst = 0;
        clr = (we && a == 4) ? d : 0;
        m_flo = slo | (m_flo & ~(clr & 1) & 1);
        m_fhi = shi | (m_fhi & ~((clr >> 1) & 1) & 1);
        if (we) case (a)
            0: m_pl = d;
            1: m_ph = d;
            2: m_cl = d;
            3: m_ch = d;
            5: m_wc = d & 7;
            default: ;
        endcase
        m_st = nst; m_cnt = ncnt; m_shd = nshd;
    endtask

    function automatic string st_tag();
        case (m_st)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic check1(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare_all(string tag);
        string t;
        t = (tag == "") ? st_tag() : tag;
        check1(t, "pwm_out (R7)", int'(pwm_out), exp_pwm());
        check1(t, "flag_lo", int'(flag_lo), m_flo);
        check1(t, "flag_hi", int'(flag_hi), m_fhi);
        check1(t, "irq (R9)", int'(irq), m_flo | m_fhi);
    endtask

    task automatic step(int md, bit tf, bit th, bit fr, bit we, int a, int d, string tag);
        mode_sel = 2'(md); tick_full = tf; tick_half = th; fine_res = fr;
        wr_en = we; wr_addr = 3'(a); wr_data = 8'(d);
        model_next(md, tf, th, fr, we, a, d);
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic wr(int md, int a, int d, string tag);
        step(md, 0, 0, 0, 1, a, d, tag);
    endtask

    task automatic run(int md, int n, bit fr, string tag);
        for (int i = 0; i < n; i++) step(md, 1, 1, fr, 0, 0, 0, tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs idle out of reset
        rst_n = 1'b1;
        @(negedge clk);
        model_next(0, 0, 0, 0, 0, 0, 0);
        check1("R1", "pwm_out", int'(pwm_out), 0);
        check1("R1", "flag_lo", int'(flag_lo), 0);
        check1("R1", "flag_hi", int'(flag_hi), 0);
        check1("R1", "irq", int'(irq), 0);

        // R2: two independent 8-bit timers
        wr(0, 0, 3, "R2"); wr(0, 1, 5, "R2");
        run(0, 40, 0, "R2");
        // R9: clear each flag separately, then both
        wr(0, 4, 1, "R9"); step(0, 0, 0, 0, 0, 0, 0, "R9");
        wr(0, 4, 2, "R9"); wr(0, 4, 3, "R9");
        // R9: set and clear in same cycle -> set wins (low period 0 matches every tick)
        wr(0, 0, 0, "R9");
        step(0, 1, 0, 0, 1, 4, 3, "R9");
        step(0, 1, 0, 0, 1, 4, 3, "R9");

        // R3: timer plus 8-bit PWM
        wr(1, 3, 64, "R3");
        run(1, 600, 0, "R3");
        // R7: compare 0 constant low, compare 255 constant high
        wr(1, 3, 0, "R7"); run(1, 300, 0, "R7");
        wr(1, 3, 255, "R7"); run(1, 300, 0, "R7");
        // R8: compare rewritten mid-period
        wr(1, 3, 200, "R8"); run(1, 300, 0, "R8");
        wr(1, 3, 20, "R8"); run(1, 400, 0, "R8");

        // R4: 16-bit timer, period 0x0110
        wr(2, 0, 8'h10, "R4"); wr(2, 1, 8'h01, "R4");
        run(2, 700, 0, "R4");
        // R6: half-cycle tick in 16-bit mode, sparse ticks
        for (int i = 0; i < 1500; i++)
            step(2, ($urandom % 4) == 0, ($urandom % 2) == 0, 1, 0, 0, 0, "R6");
        for (int i = 0; i < 600; i++)
            step(0, ($urandom % 2) == 0, 1, 1, 0, 0, 0, "R6");

        // R5: 9-bit PWM then full 16-bit PWM
        wr(3, 5, 0, "R5"); wr(3, 3, 1, "R5"); wr(3, 2, 0, "R5");
        run(3, 1200, 0, "R5");
        wr(3, 5, 7, "R5"); wr(3, 3, 8'h80, "R5");
        run(3, 30000, 1, "R5");
        wr(3, 3, 8'h10, "R8");
        run(3, 36000, 1, "R5");
        wr(3, 3, 8'hFF, "R7"); wr(3, 2, 8'hFF, "R7");
        run(3, 200, 1, "R7");

        // R10: frequent mode changes
        for (int i = 0; i < 2000; i++)
            step(($urandom % 16 == 0) ? int'($urandom % 4) : int'(mode_sel),
                 1, ($urandom % 2) == 0, ($urandom % 2) == 0, 0, 0, 0, "R10");

        // random mix
        for (int i = 0; i < 40000; i++) begin
            int md, a, d;
            bit we;
            md = (($urandom % 200) == 0) ? int'($urandom % 4) : int'(mode_sel);
            we = ($urandom % 10) == 0;
            a = int'($urandom % 6);
            d = (a == 5) ? int'($urandom % 2) : (a == 4 ? int'($urandom % 4) : int'($urandom % 20));
            step(md, ($urandom % 3) != 0, ($urandom % 2) == 0, ($urandom % 2) == 0, we, a, d, "");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule